// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Target

This block is a target on a two-wire serial bus that behaves like the read side of a small serial memory. It oversamples the clock and data lines with the local clock, finds bus START, repeated START and STOP conditions, and matches a device address made of a fixed four-bit family code and three chip-select strap inputs. The data line is open-drain: the block only ever pulls it low, through a single enable output.

A write transaction loads an 8-bit word address into an internal pointer. Any bytes that follow are acknowledged and thrown away. A read transaction returns bytes from a 256-entry array, starting at the pointer. The read continues for as long as the bus master acknowledges each byte. The pointer survives between transactions, so a bare read resumes where the last one stopped. A random read is a write of the word address, then a repeated START, then a read. The array holds all-ones. For test benches, a build parameter can instead fill it with a computed pattern.

Top module: `i2c_rd_slave`

## Requirements
- R1: A START or repeated START always begins a new device-address byte. A STOP at any point, even partway through a byte, ends the operation, releases the data line and leaves the pointer unchanged.
- R2: The device-address byte arrives MSB first. Bits 7..4 must be 1010 and bits 3..1 must equal chip_sel_i. Bit 0 is 1 for read and 0 for write. On a match the block pulls the data line low during the 9th clock.
- R3: On an address mismatch the block sends no acknowledge and never drives the data line. It ignores the bus until the next START or STOP, and the pointer is not altered.
- R4: In a write, the first byte after the address is acknowledged and becomes the pointer. Every later byte is acknowledged and discarded, and the pointer keeps the loaded value.
- R5: A repeated-START read that follows a word-address write returns the byte stored at that word address.
- R6: A read with no preceding word address returns the byte at the current pointer.
- R7: The pointer advances by one after every byte sent, wrapping from 255 to 0. When the master acknowledges (data line low in the 9th clock), the next byte follows.
- R8: When the master does not acknowledge a data byte, the read ends. The data line stays released through any later clocks until a START or STOP.
- R9: With the default build, every location reads as FFh.
- R10: Data bits are sent MSB first. The block's data-line output changes only while the clock line is low.
- R11: With FILL_MODE=1, location a holds a XOR A5h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| chip_sel_i | input | 3 | Chip-select straps compared with address bits 3..1 |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
Some checks run on every cycle. The data-line enable must change only while the sampled clock is low. A STOP must return the block to idle with the line released. A START must open an address byte. A master NACK must park the block, and the pointer must wrap from 255 to 0. The bench scenarios are needed for the rest: that the address match acknowledges in the right slot, that a loaded word address and the persisting pointer select the correct bytes across separate transactions, that discarded write data and aborted bytes leave the pointer alone, and that mismatched or parked states keep the line high across whole bytes.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_RX, S_SACK, S_TX, S_MACK
  } state_e;

  typedef enum logic [1:0] {
    K_DEV, K_WADDR, K_WDATA
  } kind_e;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_sync[SYNC_STAGES-1];
      sda_d    <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_s_o    = scl_sync[SYNC_STAGES-1];
  assign sda_s_o    = sda_sync[SYNC_STAGES-1];
  assign scl_rise_o = scl_s_o & ~scl_d;
  assign scl_fall_o = ~scl_s_o & scl_d;
  // data edges with the clock held high on both samples
  assign start_o    = scl_s_o & scl_d & sda_d & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_d & ~sda_d & sda_s_o;
endmodule

// File: rtl/i2c_rd_array.sv
module i2c_rd_array #(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter int          FILL_MODE = 0,
  parameter logic [7:0]  FILL_KEY  = 8'hA5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  generate
    if (FILL_MODE == 0) begin : g_erased
      assign data_o = '1;
    end else begin : g_pattern
      logic [DATA_W-1:0] key;
      assign key    = DATA_W'(FILL_KEY);
      assign data_o = DATA_W'(addr_i) ^ key;
    end
  endgenerate
endmodule

// File: rtl/i2c_rd_slave.sv
module i2c_rd_slave
  import i2c_rd_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         CS_W        = 3,
  parameter logic [3:0] FAMILY_ID   = 4'b1010,
  parameter int         FILL_MODE   = 0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic [CS_W-1:0] chip_sel_i,
  output logic            sda_oe_o
);
  localparam int          BYTE_W   = 8;
  localparam int          CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [ADDR_W-1:0] PTR_MAX = '1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;

  i2c_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_s_o(scl_s), .sda_s_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  state_e            state_q;
  kind_e             kind_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shreg_q, tx_q, rx_byte;
  logic [ADDR_W-1:0] ptr_q;
  logic              sda_oe_q, go_read_q;
  logic [BYTE_W-1:0] rom_data;

  i2c_rd_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W), .FILL_MODE(FILL_MODE)) u_array (
    .addr_i(ptr_q), .data_o(rom_data)
  );

  assign rx_byte = {shreg_q[BYTE_W-2:0], sda_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      kind_q    <= K_DEV;
      cnt_q     <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      sda_oe_q  <= 1'b0;
      go_read_q <= 1'b0;
    end else if (start_c) begin
      state_q  <= S_RX;
      kind_q   <= K_DEV;
      cnt_q    <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_c) begin
      state_q  <= S_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_RX: if (scl_rise) begin
          shreg_q <= rx_byte;
          if (cnt_q == CNT_W'(BYTE_W - 1)) begin
            cnt_q <= '0;
            unique case (kind_q)
              K_DEV: begin
                if (rx_byte[7:1] == {FAMILY_ID, chip_sel_i}) begin
                  state_q   <= S_SACK;
                  go_read_q <= rx_byte[0];
                end else begin
                  state_q <= S_WAIT;
                end
              end
              K_WADDR: begin
                ptr_q     <= rx_byte;
                state_q   <= S_SACK;
                go_read_q <= 1'b0;
              end
              default: begin
                state_q   <= S_SACK;
                go_read_q <= 1'b0;
              end
            endcase
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_SACK: begin
          if (cnt_q == 0 && scl_fall) begin
            sda_oe_q <= 1'b1;
            cnt_q    <= CNT_W'(1);
          end else if (cnt_q == 1 && scl_rise) begin
            cnt_q <= CNT_W'(2);
          end else if (cnt_q == 2 && scl_fall) begin
            cnt_q <= '0;
            if (go_read_q) begin
              state_q  <= S_TX;
              tx_q     <= rom_data;
              sda_oe_q <= ~rom_data[BYTE_W-1];
            end else begin
              state_q  <= S_RX;
              sda_oe_q <= 1'b0;
              kind_q   <= (kind_q == K_DEV) ? K_WADDR : K_WDATA;
            end
          end
        end
        S_TX: begin
          if (scl_rise) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == CNT_W'(BYTE_W)) begin
              sda_oe_q <= 1'b0;
              state_q  <= S_MACK;
              cnt_q    <= '0;
            end else begin
              sda_oe_q <= ~tx_q[3'(BYTE_W - 1 - int'(cnt_q))];
            end
          end
        end
        S_MACK: begin
          if (cnt_q == 0 && scl_rise) begin
            ptr_q <= ptr_q + 1'b1;
            if (sda_s) state_q <= S_WAIT;
            else       cnt_q   <= CNT_W'(1);
          end else if (cnt_q == 1 && scl_fall) begin
            state_q  <= S_TX;
            tx_q     <= rom_data;
            sda_oe_q <= ~rom_data[BYTE_W-1];
            cnt_q    <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;

  // output moves only in the low phase of the clock
  p_sda_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_q != $past(sda_oe_q)) |-> !scl_s);

  p_stop_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_c && !start_c) |=> (state_q == S_IDLE && !sda_oe_o));

  p_start_dev_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_c |=> (state_q == S_RX && kind_q == K_DEV && cnt_q == 0));

  p_nack_park_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_MACK && cnt_q == 0 && scl_rise && sda_s && !start_c && !stop_c)
      |=> (state_q == S_WAIT && !sda_oe_o));

  p_wait_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT) |-> !sda_oe_o);

  p_ptr_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_MACK && cnt_q == 0 && scl_rise && ptr_q == PTR_MAX && !start_c && !stop_c)
      |=> ptr_q == '0);
endmodule

// File: tb/tb_i2c_rd_slave.sv
module tb_i2c_rd_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic m_low = 1'b0;
  logic oe_def, oe_pat;
  wire  sda_bus = ~(m_low | oe_def | oe_pat);

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  i2c_rd_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .chip_sel_i(3'b000), .sda_oe_o(oe_def)
  );

  i2c_rd_slave #(.FILL_MODE(1)) dut_pat (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .chip_sel_i(3'b101), .sda_oe_o(oe_pat)
  );

  localparam logic [7:0] PAT_W = 8'hAA, PAT_R = 8'hAB;
  localparam logic [7:0] DEF_W = 8'hA0, DEF_R = 8'hA1;
  localparam logic [7:0] BAD_R = 8'hAF;

  task automatic wq(int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    m_low = 1'b0; wq();
    scl_m = 1'b1; wq();
    m_low = 1'b1; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop;
    scl_m = 1'b0; m_low = 1'b1; wq();
    scl_m = 1'b1; wq();
    m_low = 1'b0; wq();
  endtask

  task automatic send_bit(logic b);
    m_low = ~b; wq();
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq();
  endtask

  task automatic write_byte(logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_low = 1'b0; wq();
    scl_m = 1'b1; wq();
    acked = ~sda_bus; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic read_byte(logic ack, output logic [7:0] d, output logic stable);
    stable = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      logic s1;
      m_low = 1'b0; wq();
      scl_m = 1'b1; wq();
      s1 = sda_bus; wq();
      if (sda_bus !== s1) stable = 1'b0;
      d[i] = s1;
      scl_m = 1'b0; wq();
    end
    m_low = ack; wq();
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq();
    m_low = 1'b0;
  endtask

  task automatic set_addr(logic [7:0] dev_w, logic [7:0] wa);
    logic a;
    bus_start();
    write_byte(dev_w, a); chk("R2 write address ack", a, 1);
    write_byte(wa, a);    chk("R4 word address ack", a, 1);
  endtask

  task automatic cur_read(logic [7:0] dev_r, logic [7:0] exp, string req);
    logic a, st; logic [7:0] d;
    bus_start();
    write_byte(dev_r, a); chk("R2 read address ack", a, 1);
    read_byte(1'b0, d, st);
    chk(req, d, exp);
    chk("R10 bits stable while clock high", st, 1);
    bus_stop();
  endtask

  task automatic t_reset;
    chk("R1 reset releases line dut", oe_def, 0);
    chk("R1 reset releases line dut_pat", oe_pat, 0);
    chk("R1 reset bus high", sda_bus, 1);
  endtask

  task automatic t_random;
    set_addr(PAT_W, 8'h10);
    cur_read(PAT_R, 8'h10 ^ 8'hA5, "R5 R11 random read data");
  endtask

  task automatic t_current;
    cur_read(PAT_R, 8'h11 ^ 8'hA5, "R6 current address read");
  endtask

  task automatic t_sequential;
    logic a, st; logic [7:0] d;
    set_addr(PAT_W, 8'hFE);
    bus_start();
    write_byte(PAT_R, a); chk("R2 repeated start ack", a, 1);
    read_byte(1'b1, d, st); chk("R7 seq byte FE", d, 8'hFE ^ 8'hA5);
    read_byte(1'b1, d, st); chk("R7 seq byte FF", d, 8'hFF ^ 8'hA5);
    read_byte(1'b1, d, st); chk("R7 seq wrap to 00", d, 8'h00 ^ 8'hA5);
    read_byte(1'b0, d, st); chk("R7 seq byte 01", d, 8'h01 ^ 8'hA5);
    bus_stop();
    cur_read(PAT_R, 8'h02 ^ 8'hA5, "R7 pointer after sequence");
  endtask

  task automatic t_mismatch;
    logic a, st; logic [7:0] d;
    bus_start();
    write_byte(BAD_R, a); chk("R3 no ack on mismatch", a, 0);
    read_byte(1'b0, d, st); chk("R3 line untouched after mismatch", d, 8'hFF);
    bus_stop();
    cur_read(PAT_R, 8'h03 ^ 8'hA5, "R3 pointer unchanged");
  endtask

  task automatic t_write_discard;
    logic a;
    set_addr(PAT_W, 8'h40);
    write_byte(8'h12, a); chk("R4 data byte ack 1", a, 1);
    write_byte(8'h34, a); chk("R4 data byte ack 2", a, 1);
    bus_stop();
    cur_read(PAT_R, 8'h40 ^ 8'hA5, "R4 pointer keeps word address");
  endtask

  task automatic t_nack_release;
    logic a, st; logic [7:0] d;
    bus_start();
    write_byte(PAT_R, a); chk("R2 read ack", a, 1);
    read_byte(1'b0, d, st); chk("R8 byte before nack", d, 8'h41 ^ 8'hA5);
    read_byte(1'b0, d, st); chk("R8 line released after nack", d, 8'hFF);
    bus_stop();
    cur_read(PAT_R, 8'h42 ^ 8'hA5, "R8 pointer stops after nack");
  endtask

  task automatic t_stop_abort;
    logic a;
    bus_start();
    write_byte(PAT_W, a); chk("R2 write ack", a, 1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    bus_stop();
    chk("R1 line released after stop", sda_bus, 1);
    cur_read(PAT_R, 8'h43 ^ 8'hA5, "R1 stop mid byte keeps pointer");
  endtask

  task automatic t_default_fill;
    logic a, st; logic [7:0] d;
    set_addr(DEF_W, 8'h33);
    bus_start();
    write_byte(DEF_R, a); chk("R2 default dev ack", a, 1);
    read_byte(1'b1, d, st); chk("R9 erased byte 33", d, 8'hFF);
    read_byte(1'b0, d, st); chk("R9 erased byte 34", d, 8'hFF);
    bus_stop();
  endtask

  initial begin
    wq(5);
    rst_n = 1'b1;
    wq(5);
    t_reset();
    t_random();
    t_current();
    t_sequential();
    t_mismatch();
    t_write_discard();
    t_nack_release();
    t_stop_abort();
    t_default_fill();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule